// File: doc/BRIEF.md
# Power-On Calibration Sequencer

This block controls start-up self-calibration for a data converter core. Two supply-good inputs, one for the analog rail and one for the digital rail, and an external active-low reset pin are each brought into the clock domain through two flip-flops. They are then combined into an internal active-low core reset. Every release of that reset launches a calibration run. The run sends a one-cycle start pulse to the calibration engine, then waits for the engine's done pulse or for a timeout counter to expire.

A small register port sits beside the sequencer. Until calibration has finished, the port accepts only reads of the status register at address 0xB6. Any other access returns zero and raises an error flag. A "link valid" output tells the serial transmitter when its data can be trusted.

The sequencer has four states:
- POR_HOLD: a supply is not good.
- IDLE_RESET: the supplies are good but the external pin holds reset low.
- CALIBRATING: a run is in progress.
- READY: normal operation.

Its transitions are:
- Any state goes to POR_HOLD when a synchronised supply-good is low.
- Any state goes to IDLE_RESET when both supplies are good but the synchronised external pin is low.
- POR_HOLD or IDLE_RESET goes to CALIBRATING when the reset line is released.
- CALIBRATING goes to READY on done or on timeout.
- READY stays in READY.

Top module: `cal_sequencer`

## Requirements
- R1: `core_rst_n` is low while either synchronised supply-good input is low or the synchronised external pin is low. It is high only when all three are high.
- R2: Each rising edge of `core_rst_n` starts a calibration. `cal_start` is high for exactly one cycle, in the same cycle that `core_rst_n` first reads high.
- R3: Reading address 0xB6 returns bit 0 = 1 when calibration has completed and 0 otherwise, bit 1 = the timeout flag, and bits 7:2 = 0.
- R4: While the sequencer is not in READY, every write is rejected, and so is every read except a read of 0xB6. A read of 0xB6 is always accepted.
- R5: `link_valid` is high only in READY.
- R6: A `cal_done` pulse sampled during CALIBRATING moves the sequencer to READY at that clock edge. From then on `link_valid` is high and the port is fully open.
- R7: A rejected access returns `rsp_rdata` = 0 and `rsp_err` = 1 for that one response, and it changes no register.
- R8: If TIMEOUT_CYC cycles pass in CALIBRATING without done, the sequencer enters READY with status bits 0 and 1 both set. Bit 1 clears when the next calibration starts.
- R9: If done arrives in the same cycle that the timeout expires, the done wins and status bit 1 stays 0.
- R10: Pulling the external pin low during calibration aborts the run at once, so status bit 0 reads 0. A fresh calibration starts when the pin is released.
- R11: A change on a supply-good input or on the external pin reaches the outputs at the third rising clock edge after the change.
- R12: Once READY, a write to addresses 0 through N_USER-1 stores its data and a read returns it. A read of an unmapped address returns 0 without error. A write to 0xB6 is ignored and raises no error.
- R13: Every request is answered at the next clock edge with `rsp_valid` high for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer logic |
| ana_pwr_ok | input | 1 | Analog supply above threshold (asynchronous) |
| dig_pwr_ok | input | 1 | Digital supply above threshold (asynchronous) |
| ext_rst_n | input | 1 | External active-low reset pin (asynchronous) |
| cal_done | input | 1 | One-cycle done pulse from the calibration engine |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Register address |
| req_wdata | input | 8 | Write data |
| cal_start | output | 1 | One-cycle start pulse to the calibration engine |
| core_rst_n | output | 1 | Internal active-low core reset |
| link_valid | output | 1 | Serial transmitter output is meaningful |
| rsp_valid | output | 1 | Response strobe |
| rsp_err | output | 1 | Access was rejected |
| rsp_rdata | output | 8 | Read data |

## Verification
The done pulse and the timeout expiry can land on the same clock edge. The bench provokes this by watching its own model's cycle count in CALIBRATING and driving `cal_done` so that it is sampled on the expiry edge. It then reads 0xB6 and expects 0x01: done, with no timeout flag. A second collision happens between a register access and the state change at the same edge. It is judged by the rule that the gate uses the state held before the edge, so a request sampled on the edge that enters READY is still rejected.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;
    typedef enum logic [1:0] {
        POR_HOLD    = 2'd0,
        IDLE_RESET  = 2'd1,
        CALIBRATING = 2'd2,
        READY       = 2'd3
    } seq_state_t;
endpackage

// File: rtl/cal_sync.sv
module cal_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage1[i] <= 1'b0;
                q[i]      <= 1'b0;
            end else begin
                stage1[i] <= d[i];
                q[i]      <= stage1[i];
            end
        end
    end
endmodule

// File: rtl/cal_fsm.sv
module cal_fsm
    import cal_seq_pkg::*;
#(
    parameter int TIMEOUT_CYC = 137_500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_ok,
    input  logic ext_ok,
    input  logic cal_done,
    output logic cal_start,
    output logic core_rst_n,
    output logic link_valid,
    output logic tmo_flag,
    output logic ready
);
    localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYC - 1);

    seq_state_t st, nxt;
    logic [CNT_W-1:0] cnt;
    logic expire;

    assign expire = (st == CALIBRATING) && (cnt == CNT_LAST);
    assign ready  = (st == READY);

    always_comb begin
        nxt = st;
        if (!pwr_ok) begin
            nxt = POR_HOLD;
        end else if (!ext_ok) begin
            nxt = IDLE_RESET;
        end else begin
            unique case (st)
                POR_HOLD, IDLE_RESET: nxt = CALIBRATING;
                CALIBRATING:          if (cal_done || expire) nxt = READY;
                READY:                nxt = READY;
                default:              nxt = POR_HOLD;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= POR_HOLD;
            cnt <= '0;
        end else begin
            st  <= nxt;
            cnt <= (st == CALIBRATING) ? cnt + 1'b1 : '0;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cal_start  <= 1'b0;
            core_rst_n <= 1'b0;
            link_valid <= 1'b0;
            tmo_flag   <= 1'b0;
        end else begin
            cal_start  <= (nxt == CALIBRATING) && (st != CALIBRATING);
            core_rst_n <= (nxt == CALIBRATING) || (nxt == READY);
            link_valid <= (nxt == READY);
            if ((nxt == CALIBRATING) && (st != CALIBRATING))
                tmo_flag <= 1'b0;
            else if (expire && !cal_done && (nxt == READY))
                tmo_flag <= 1'b1;
        end
    end

    AST_RST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |=> !core_rst_n); // R1
    AST_START_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_rst_n) |-> cal_start); // R2
    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cal_start |=> !cal_start); // R2
    AST_LINK_NEEDS_RESET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        link_valid |-> core_rst_n); // R5
    AST_TIMEOUT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_flag) |-> link_valid); // R8
endmodule

// File: rtl/cal_reg_gate.sv
module cal_reg_gate #(
    parameter int              ADDR_W      = 8,
    parameter int              DATA_W      = 8,
    parameter int              N_USER      = 4,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'hB6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ready,
    input  logic              tmo_flag,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata
);
    localparam int IDX_W = (N_USER > 1) ? $clog2(N_USER) : 1;

    logic [DATA_W-1:0] regs [N_USER];
    logic [IDX_W-1:0]  idx;
    logic              is_stat, is_user, allowed;
    logic [DATA_W-1:0] rd_val;

    assign idx     = req_addr[IDX_W-1:0];
    assign is_stat = (req_addr == STATUS_ADDR);
    assign is_user = (req_addr < ADDR_W'(N_USER));
    assign allowed = ready || (!req_write && is_stat);

    always_comb begin
        rd_val = '0;
        if (is_stat)      rd_val = {{(DATA_W-2){1'b0}}, tmo_flag, ready};
        else if (is_user) rd_val = regs[idx];
    end

    for (genvar i = 0; i < N_USER; i++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                regs[i] <= '0;
            else if (req_valid && req_write && allowed && is_user && (idx == IDX_W'(i)))
                regs[i] <= req_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid && !allowed;
            rsp_rdata <= (req_valid && allowed && !req_write) ? rd_val : '0;
        end
    end

    AST_REJECT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_rdata == '0)); // R7
    AST_BUSY_WRITE_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && req_valid && req_write) |=> rsp_err); // R4
    AST_STATUS_READ_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && is_stat) |=> !rsp_err); // R4
    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_valid); // R13
endmodule

// File: rtl/cal_sequencer.sv
module cal_sequencer #(
    parameter int TIMEOUT_CYC = 137_500_000,
    parameter int N_USER      = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ana_pwr_ok,
    input  logic       dig_pwr_ok,
    input  logic       ext_rst_n,
    input  logic       cal_done,
    input  logic       req_valid,
    input  logic       req_write,
    input  logic [7:0] req_addr,
    input  logic [7:0] req_wdata,
    output logic       cal_start,
    output logic       core_rst_n,
    output logic       link_valid,
    output logic       rsp_valid,
    output logic       rsp_err,
    output logic [7:0] rsp_rdata
);
    logic [2:0] raw_in, sync_in;
    logic       ready, tmo_flag;

    assign raw_in = {ext_rst_n, dig_pwr_ok, ana_pwr_ok};

    cal_sync #(.W(3)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_in)
    );

    cal_fsm #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .pwr_ok(sync_in[0] & sync_in[1]), .ext_ok(sync_in[2]),
        .cal_done(cal_done), .cal_start(cal_start), .core_rst_n(core_rst_n),
        .link_valid(link_valid), .tmo_flag(tmo_flag), .ready(ready)
    );

    cal_reg_gate #(.ADDR_W(8), .DATA_W(8), .N_USER(N_USER), .STATUS_ADDR(8'hB6)) u_gate (
        .clk(clk), .rst_n(rst_n), .ready(ready), .tmo_flag(tmo_flag),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata)
    );
endmodule

// File: tb/sim_cal_sequencer.sv
module sim_cal_sequencer;
    localparam int T = 40;
    localparam int NU = 4;

    logic clk = 0, rst_n = 0;
    logic ana = 0, dig = 0, ext = 0, done = 0;
    logic rv = 0, rw = 0;
    logic [7:0] ra = 0, wd = 0;
    logic cal_start, core_rst_n, link_valid, rsp_valid, rsp_err;
    logic [7:0] rsp_rdata;

    int checks = 0, errors = 0;
    bit finished = 0;

    // behavioural reference model: 0 hold, 1 idle, 2 cal, 3 ready
    int m_st = 0, m_cnt = 0;
    bit m_tmo = 0, m_start = 0, m_rstn = 0, m_link = 0;
    bit m_rv = 0, m_err = 0;
    logic [7:0] m_rd = 0;
    logic [7:0] m_regs [NU];
    bit q1 [3];
    bit q2 [3];

    always #2.5 clk = ~clk;

    cal_sequencer #(.TIMEOUT_CYC(T), .N_USER(NU)) u0 (
        .clk(clk), .rst_n(rst_n), .ana_pwr_ok(ana), .dig_pwr_ok(dig),
        .ext_rst_n(ext), .cal_done(done), .req_valid(rv), .req_write(rw),
        .req_addr(ra), .req_wdata(wd), .cal_start(cal_start),
        .core_rst_n(core_rst_n), .link_valid(link_valid), .rsp_valid(rsp_valid),
        .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_tmo = 0; m_start = 0; m_rstn = 0; m_link = 0;
            m_rv = 0; m_err = 0; m_rd = 0;
            for (int i = 0; i < NU; i++) m_regs[i] = 0;
            for (int i = 0; i < 3; i++) begin q1[i] = 0; q2[i] = 0; end
        end else begin
            bit ok, p_ok, e_ok, expd;
            int nx;
            logic [7:0] val;
            // register port, judged on state before this edge (R4, R7, R12, R13)
            ok = (m_st == 3) || (!rw && ra == 8'hB6);
            val = 0;
            if (ra == 8'hB6) val = {6'b0, m_tmo, m_st == 3};
            else if (ra < NU) val = m_regs[ra];
            m_rv = rv;
            m_err = rv && !ok;
            m_rd = (rv && ok && !rw) ? val : 8'h00;
            if (rv && ok && rw && ra < NU) m_regs[ra] = wd;
            // two-stage input delay (R11)
            p_ok = q2[0] && q2[1];
            e_ok = q2[2];
            q2 = q1;
            q1[0] = ana; q1[1] = dig; q1[2] = ext;
            // sequencing (R1, R2, R6, R8, R9, R10)
            expd = (m_st == 2) && (m_cnt == T - 1);
            if (!p_ok) nx = 0;
            else if (!e_ok) nx = 1;
            else if (m_st < 2) nx = 2;
            else if (m_st == 2) nx = (done || expd) ? 3 : 2;
            else nx = 3;
            m_start = (nx == 2) && (m_st != 2);
            if (m_start) m_tmo = 0;
            else if (expd && !done && nx == 3) m_tmo = 1;
            m_cnt = (m_st == 2) ? m_cnt + 1 : 0;
            m_rstn = (nx >= 2);
            m_link = (nx == 3);
            m_st = nx;
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!finished) begin
            chk("R1 core_rst_n", {7'b0, core_rst_n}, {7'b0, m_rstn});
            chk("R2 cal_start", {7'b0, cal_start}, {7'b0, m_start});
            chk("R5 link_valid", {7'b0, link_valid}, {7'b0, m_link});
            chk("R13 rsp_valid", {7'b0, rsp_valid}, {7'b0, m_rv});
            chk("R7 rsp_err", {7'b0, rsp_err}, {7'b0, m_err});
            chk("R3 rsp_rdata", rsp_rdata, m_rd);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic acc(input bit w, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); rv = 1; rw = w; ra = a; wd = d;
        @(negedge clk); rv = 0; rw = 0;
    endtask

    task automatic pulse_done();
        @(negedge clk); done = 1;
        @(negedge clk); done = 0;
    endtask

    task automatic wrap_up();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        wrap_up();
    end

    initial begin
        cyc(3);
        rst_n = 1;
        cyc(3);
        // R1: one supply alone keeps reset held
        ana = 1; ext = 1;
        cyc(6);
        chk("R1 held on one supply", {7'b0, core_rst_n}, 8'h00);
        dig = 1;                       // R11: effect three edges later
        cyc(3);
        chk("R2 start after release", {7'b0, cal_start}, 8'h01);
        // R4, R7: gated access during calibration
        acc(1, 8'h00, 8'hAA);
        acc(0, 8'h00, 8'h00);
        acc(0, 8'h40, 8'h00);
        acc(0, 8'hB6, 8'h00);
        acc(1, 8'hB6, 8'hFF);
        pulse_done();                  // R6
        cyc(1);
        chk("R6 link after done", {7'b0, link_valid}, 8'h01);
        // R12: normal access
        acc(0, 8'h00, 8'h00);          // R7: rejected write left 0
        acc(1, 8'h00, 8'h5A);
        acc(1, 8'h03, 8'hC3);
        acc(0, 8'h00, 8'h00);
        acc(0, 8'h03, 8'h00);
        acc(0, 8'h40, 8'h00);
        acc(1, 8'hB6, 8'hFF);
        acc(0, 8'hB6, 8'h00);          // R3: expect 0x01
        // R8: timeout path
        @(negedge clk); ext = 0;
        cyc(5); ext = 1;
        cyc(T + 8);
        acc(0, 8'hB6, 8'h00);          // expect 0x03
        // R10: abort mid calibration
        @(negedge clk); ext = 0;
        cyc(4); ext = 1;
        cyc(10);
        acc(0, 8'hB6, 8'h00);          // R8: bit 1 cleared on new start
        @(negedge clk); ext = 0;
        cyc(4);
        acc(0, 8'hB6, 8'h00);          // R10: bit 0 reads 0
        ext = 1;
        // R9: done on the expiry edge
        while (!(m_st == 2 && m_cnt == T - 1)) @(negedge clk);
        done = 1;
        @(negedge clk); done = 0;
        chk("R9 ready at expiry", {7'b0, link_valid}, 8'h01);
        acc(0, 8'hB6, 8'h00);          // expect 0x01
        // R1: supply drop from READY
        @(negedge clk); dig = 0;
        cyc(4);
        chk("R1 supply drop", {7'b0, core_rst_n}, 8'h00);
        acc(0, 8'h00, 8'h00);
        dig = 1;
        cyc(8);
        wrap_up();
    end
endmodule